// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

A single down-counting timer channel for a programmable interval timer. Software (or a
surrounding register block) hands it an initial count together with a one-cycle load
strobe and a 3-bit mode. From then on every cycle in which the counter clock enable is
high is one counter tick. The channel shapes its `out` line as one of six waveforms.
Modes 0 and 4 use the gate input as a level enable. Modes 1 and 5 use a rising gate edge
as a trigger. Modes 2 and 3 do both.

The live count is exposed so that an outer block can latch it for readback. Counting is
plain binary. A loaded value of zero stands for the full range, 2^CW ticks. Mode codes 6
and 7 are aliases of 2 and 3. The bus interface, byte ordering and decimal counting are
left to the surrounding logic.

Top module: `tmr_channel`

## Requirements
- R1: While reset is active and until the first load after reset, `count` is 0 and `out` is low, and the count does not change on ticks.
- R2: A cycle with `load` high sets `count` to `load_val` on that edge and restarts the channel. `mode_sel` is captured on the same edge, and codes 6 and 7 act as modes 2 and 3. `out` becomes low in mode 0 and high in every other mode. A load takes priority over a tick or a gate edge in the same cycle.
- R3: In mode 0, `out` goes high on the edge of the N-th tick after a load of N and stays high until the next load. `count` keeps decrementing and wraps modulo 2^CW.
- R4: In modes 0, 2, 3 and 4, ticks taken while `gate` is low leave `count` unchanged. In mode 0 a rising gate edge does not restart the count.
- R5: In mode 1, nothing counts after a load until a rising gate edge. That edge reloads `count` with the initial value and drives `out` low. `out` returns high after N further ticks. A later rising edge retriggers, and the gate level does not pause counting.
- R6: In mode 2 the period is N ticks. `out` is low only during the one tick in which `count` equals 1, and the next tick reloads N.
- R7: In mode 3, `out` is high for (N+1)/2 ticks and low for N/2 ticks of each period, toggling on each reload. An even `count` drops by 2 per tick. With odd N, the first tick after a reload subtracts 1 in the high half and 3 in the low half.
- R8: In mode 4, `out` is high except for a single one-tick low strobe on the N-th tick after a load. The strobe does not repeat when the count wraps.
- R9: In mode 5, a rising gate edge reloads `count` and arms a single one-tick low strobe on the N-th tick after that edge. Nothing counts before the first edge.
- R10: In modes 2 and 3, while `gate` is low, `out` is forced high on the next edge. A rising gate edge reloads N and starts a new period with `out` high.
- R11: A cycle with `cnt_en` low is not a tick: `count` and the waveform hold.
- R12: A loaded value of 0 behaves as 2^CW. In mode 0, `out` rises after exactly 65536 ticks at the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Counter tick enable, one tick per high cycle |
| load | input | 1 | Load strobe for a new initial count and mode |
| load_val | input | CW | Initial count, 0 meaning 2^CW |
| mode_sel | input | 3 | Operating mode captured at load |
| gate | input | 1 | Gate level / trigger input |
| count | output | CW | Live count value |
| out | output | 1 | Timer output waveform |

## Verification
The bound checker watches, on every cycle, the properties that hold locally:
- the loaded value appears on the next edge;
- the count freezes when there is no tick, no load and no gate edge;
- the mode 0 output is sticky high;
- the mode 2 low phase coincides with a count of one;
- the strobe modes release their low pulse after one tick;
- the forced-high output of modes 2 and 3 under a low gate.

Exact periods, the uneven split of odd square waves, trigger-before-count in modes 1 and 5, the no-repeat of strobes and the full-range meaning of zero depend on long tick sequences. Only the bench's scenarios, with counts computed from the requirements, show these.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic tmr_mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return tmr_mode_e'({1'b0, code[1:0]});
    return tmr_mode_e'(code);
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tmr_step.sv
// One counter tick: next count, output and arm flag for the current mode.
module tmr_step
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  tmr_mode_e       mode,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   init,
  input  logic            out_q,
  input  logic            armed_q,
  output logic [CW-1:0]   cnt_n,
  output logic            out_n,
  output logic            armed_n
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);
  localparam logic [CW-1:0] TRI  = CW'(3);

  logic [CW-1:0] dec;
  logic [CW-1:0] dif;
  logic          term;

  always_comb begin
    dec = ONE;
    if (mode == M_SQUARE) begin
      // odd value only right after a reload: trim the half-period
      if (cnt[0]) dec = out_q ? ONE : TRI;
      else        dec = TWO;
    end
    dif  = cnt - dec;
    term = armed_q && (cnt == ONE);

    cnt_n   = dif;
    out_n   = out_q;
    armed_n = armed_q;
    case (mode)
      M_TERM, M_ONESHOT: begin
        if (term) begin
          out_n   = 1'b1;
          armed_n = 1'b0;
        end
      end
      M_RATE: begin
        if (cnt == ONE) begin
          cnt_n = init;
          out_n = 1'b1;
        end else begin
          out_n = (dif != ONE);
        end
      end
      M_SQUARE: begin
        if (cnt == dec) begin
          cnt_n = init;
          out_n = ~out_q;
        end
      end
      default: begin
        if (term) begin
          out_n   = 1'b0;
          armed_n = 1'b0;
        end else begin
          out_n = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_sel,
  input  logic          gate,
  output logic [CW-1:0] count,
  output logic          out
);
  logic          rst_sn;
  logic          gate_rise;

  tmr_mode_e     mode_q, mode_d;
  logic [CW-1:0] init_q, init_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          out_q,  out_d;
  logic          run_q,  run_d;
  logic          armed_q, armed_d;

  logic [CW-1:0] stp_cnt;
  logic          stp_out;
  logic          stp_armed;

  tmr_mode_e     ld_mode;
  logic          trig_mode;
  logic          force_mode;
  logic          free_mode;
  logic          tick_ok;

  tmr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tmr_gate_edge u_gedge (
    .clk    (clk),
    .rst_n  (rst_sn),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  tmr_step #(.CW(CW)) u_step (
    .mode    (mode_q),
    .cnt     (cnt_q),
    .init    (init_q),
    .out_q   (out_q),
    .armed_q (armed_q),
    .cnt_n   (stp_cnt),
    .out_n   (stp_out),
    .armed_n (stp_armed)
  );

  always_comb begin
    ld_mode    = norm_mode(mode_sel);
    trig_mode  = mode_q inside {M_ONESHOT, M_RATE, M_SQUARE, M_HWSTB};
    force_mode = mode_q inside {M_RATE, M_SQUARE};
    free_mode  = mode_q inside {M_ONESHOT, M_HWSTB};
    tick_ok    = gate || free_mode;

    mode_d  = mode_q;
    init_d  = init_q;
    cnt_d   = cnt_q;
    out_d   = out_q;
    run_d   = run_q;
    armed_d = armed_q;

    if (load) begin
      mode_d  = ld_mode;
      init_d  = load_val;
      cnt_d   = load_val;
      out_d   = (ld_mode != M_TERM);
      run_d   = !(ld_mode inside {M_ONESHOT, M_HWSTB});
      armed_d = !(ld_mode inside {M_ONESHOT, M_HWSTB});
    end else if (gate_rise && trig_mode) begin
      cnt_d   = init_q;
      run_d   = 1'b1;
      armed_d = 1'b1;
      out_d   = (mode_q != M_ONESHOT);
    end else if (force_mode && !gate) begin
      out_d   = 1'b1;
    end else if (cnt_en && run_q) begin
      if (tick_ok) begin
        cnt_d   = stp_cnt;
        out_d   = stp_out;
        armed_d = stp_armed;
      end else if (mode_q == M_SWSTB) begin
        out_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q  <= M_TERM;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      init_q  <= init_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end

  assign count = cnt_q;
  assign out   = out_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          cnt_en,
  input logic          load,
  input logic [CW-1:0] load_val,
  input logic [2:0]    mode_sel,
  input logic          gate,
  input logic [CW-1:0] count,
  input logic          out
);
  logic      gate_d;
  tmr_mode_e cur_mode;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gate_d   <= 1'b0;
      cur_mode <= M_TERM;
    end else begin
      gate_d   <= gate;
      if (load) cur_mode <= norm_mode(mode_sel);
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    load |=> (count == $past(load_val)));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cnt_en && !load && !(gate && !gate_d)) |=> $stable(count));

  // R3
  term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cur_mode == M_TERM && out && !load) |=> out);

  // R6
  rate_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cur_mode == M_RATE && !out) |-> (count == CW'(1)));

  // R10
  gate_force_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((cur_mode == M_RATE || cur_mode == M_SQUARE) && !gate && !load) |=> out);

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((cur_mode == M_SWSTB || cur_mode == M_HWSTB) && !out && cnt_en && !load) |=> out);
endmodule

bind tmr_channel tmr_channel_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cnt_en   (cnt_en),
  .load     (load),
  .load_val (load_val),
  .mode_sel (mode_sel),
  .gate     (gate),
  .count    (count),
  .out      (out)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 22;

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] n;
    logic [15:0] t;
    logic [15:0] c;
    logic        o;
  } vec_t;

  // mode, initial count, ticks after load, expected count, expected out
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd5, 16'd4, 16'd1,      1'b0},
    '{3'd0, 16'd5, 16'd5, 16'd0,      1'b1},
    '{3'd0, 16'd5, 16'd7, 16'hFFFE,   1'b1},
    '{3'd2, 16'd4, 16'd2, 16'd2,      1'b1},
    '{3'd2, 16'd4, 16'd3, 16'd1,      1'b0},
    '{3'd2, 16'd4, 16'd4, 16'd4,      1'b1},
    '{3'd2, 16'd4, 16'd7, 16'd1,      1'b0},
    '{3'd3, 16'd5, 16'd2, 16'd2,      1'b1},
    '{3'd3, 16'd5, 16'd3, 16'd5,      1'b0},
    '{3'd3, 16'd5, 16'd4, 16'd2,      1'b0},
    '{3'd3, 16'd5, 16'd5, 16'd5,      1'b1},
    '{3'd3, 16'd4, 16'd1, 16'd2,      1'b1},
    '{3'd3, 16'd4, 16'd2, 16'd4,      1'b0},
    '{3'd3, 16'd4, 16'd3, 16'd2,      1'b0},
    '{3'd3, 16'd4, 16'd4, 16'd4,      1'b1},
    '{3'd4, 16'd3, 16'd2, 16'd1,      1'b1},
    '{3'd4, 16'd3, 16'd3, 16'd0,      1'b0},
    '{3'd4, 16'd3, 16'd4, 16'hFFFF,   1'b1},
    '{3'd4, 16'd3, 16'd6, 16'hFFFD,   1'b1},
    '{3'd6, 16'd3, 16'd2, 16'd1,      1'b0},
    '{3'd7, 16'd3, 16'd1, 16'd2,      1'b1},
    '{3'd7, 16'd3, 16'd2, 16'd3,      1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic        load;
  logic [15:0] load_val;
  logic [2:0]  mode_sel;
  logic        gate;
  logic [15:0] count;
  logic        out;

  int checks;
  int errors;
  bit done;

  tmr_channel u_tmr_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .load     (load),
    .load_val (load_val),
    .mode_sel (mode_sel),
    .gate     (gate),
    .count    (count),
    .out      (out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0:    return "R3";
      3'd2:    return "R6";
      3'd3:    return "R7";
      3'd4:    return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp_c, input logic exp_o);
    checks++;
    if (count !== exp_c || out !== exp_o) begin
      errors++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               req, count, out, exp_c, exp_o);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ch(input logic [2:0] m, input logic [15:0] n);
    @(negedge clk);
    load     = 1'b1;
    mode_sel = m;
    load_val = n;
    @(negedge clk);
    load     = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    cnt_en   = 1'b1;
    load     = 1'b0;
    load_val = '0;
    mode_sel = '0;
    gate     = 1'b0;

    // R1: reset state and no counting before the first load
    step(3);
    check("R1", 16'd0, 1'b0);
    rst_n = 1'b1;
    step(6);
    check("R1", 16'd0, 1'b0);

    // table walk: R2 R3 R6 R7 R8
    gate = 1'b1;
    for (int i = 0; i < NV; i++) begin
      load_ch(VECS[i].m, VECS[i].n);
      step(int'(VECS[i].t));
      check(tag_of(VECS[i].m), VECS[i].c, VECS[i].o);
    end

    // R4: mode 0 pauses while gate is low, rising edge does not restart
    load_ch(3'd0, 16'd5);
    step(2);
    check("R4", 16'd3, 1'b0);
    gate = 1'b0;
    step(4);
    check("R4", 16'd3, 1'b0);
    gate = 1'b1;
    step(3);
    check("R4", 16'd0, 1'b1);

    // R5: mode 1 waits for trigger, then one-shot, then retrigger
    gate = 1'b0;
    load_ch(3'd1, 16'd3);
    check("R5", 16'd3, 1'b1);
    step(2);
    check("R5", 16'd3, 1'b1);
    gate = 1'b1;
    step(1);
    check("R5", 16'd3, 1'b0);
    step(2);
    check("R5", 16'd1, 1'b0);
    step(1);
    check("R5", 16'd0, 1'b1);
    gate = 1'b0;
    step(1);
    check("R5", 16'hFFFF, 1'b1);
    gate = 1'b1;
    step(1);
    check("R5", 16'd3, 1'b0);

    // R9: mode 5 hardware strobe after gate edge, no repeat
    gate = 1'b0;
    load_ch(3'd5, 16'd2);
    step(3);
    check("R9", 16'd2, 1'b1);
    gate = 1'b1;
    step(1);
    check("R9", 16'd2, 1'b1);
    step(1);
    check("R9", 16'd1, 1'b1);
    step(1);
    check("R9", 16'd0, 1'b0);
    step(1);
    check("R9", 16'hFFFF, 1'b1);
    step(5);
    check("R9", 16'hFFFA, 1'b1);

    // R10: mode 2 gate pause then edge restart
    load_ch(3'd2, 16'd4);
    step(2);
    check("R10", 16'd2, 1'b1);
    gate = 1'b0;
    step(2);
    check("R10", 16'd2, 1'b1);
    gate = 1'b1;
    step(1);
    check("R10", 16'd4, 1'b1);
    step(3);
    check("R10", 16'd1, 1'b0);

    // R10: mode 3 low half forced high by a low gate
    load_ch(3'd3, 16'd4);
    step(2);
    check("R10", 16'd4, 1'b0);
    gate = 1'b0;
    step(1);
    check("R10", 16'd4, 1'b1);
    step(2);
    check("R10", 16'd4, 1'b1);
    gate = 1'b1;

    // R11: no tick without cnt_en
    cnt_en = 1'b0;
    load_ch(3'd0, 16'd3);
    step(5);
    check("R11", 16'd3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cnt_en = 1'b1;
      step(1);
      cnt_en = 1'b0;
      step(1);
    end
    check("R11", 16'd0, 1'b1);
    cnt_en = 1'b1;

    // R12: zero loads the full range
    load_ch(3'd0, 16'd0);
    step(65535);
    check("R12", 16'd1, 1'b0);
    step(1);
    check("R12", 16'd0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule